// File: doc/BRIEF.md
# Resynchronization Pattern Sequencer

This block sits on the transmit side of a serial video link and runs on the pixel clock. Whenever a control-channel phase ends, it looks at the handshake result. If the receiver returned its lock frame, the block sends a short synchronization pattern. If no lock frame came back, it sends a long one. It counts the pattern words, one per pixel clock, raises `pat_active` while a pattern is being sent, and pulses `video_start` once the last word has gone out. Pattern contents and line coding belong to other blocks.

The block also counts consecutive failed handshakes. A lock frame clears that count. In remote mode, once the limit of consecutive failures is reached, the block clears the serializer enable and parks in a halt state, so the control channel stays open for troubleshooting. Only a reset brings it out of that state. With remote mode off, the block keeps retrying without limit. The short pattern length depends on the 2-bit rate code. That code is captured in the cycle the pattern starts and has no effect after that.

States:
- `ST_LONG`: a long pattern is being sent; this is also the reset state.
- `ST_SHORT`: a short pattern is being sent.
- `ST_VSTART`: the one-cycle video-start pulse.
- `ST_VIDEO`: the block waits for the end of a control channel.
- `ST_HALT`: the serializer is disabled.

Transitions:
- `ST_LONG`/`ST_SHORT` go to `ST_VSTART` on the last word.
- `ST_VSTART` goes to `ST_VIDEO` unconditionally.
- `ST_VIDEO` leaves on `cc_end`:
  - to `ST_SHORT` if a lock frame was received;
  - to `ST_HALT` on the final allowed failure in remote mode;
  - to `ST_LONG` otherwise.
- `ST_HALT` stays in `ST_HALT`.

Top module: `resync_seq`

## Requirements
- R1: After reset is released, the block sends a long pattern of LONG_LEN words: `pat_active` is high for LONG_LEN cycles, `ser_en` is high, and `video_start` is low.
- R2: When `cc_end` is seen in the video state with `lock_frame` high and `rate` equal to 0 or 1, `pat_active` is high for SHORT_LO words (546 by default), starting in the cycle after that edge.
- R3: Under the same conditions with `rate` equal to 2 or 3 (rate bit 1 set), the short pattern is SHORT_HI words long (1090 by default).
- R4: When `cc_end` is seen in the video state with `lock_frame` low, and no halt results, the block sends a long pattern of LONG_LEN words (17410 by default).
- R5: `video_start` is high for exactly one cycle, in the cycle right after the last pattern word, and `pat_active` is low in that cycle.
- R6: The rate code is captured at pattern start; changing `rate` during a pattern does not change its length.
- R7: With `remote` high, the RETRY_LIMIT-th consecutive failure (62 by default) clears `ser_en` instead of starting a pattern. After that, `ser_en` stays low and `pat_active` and `video_start` stay low whatever `cc_end` does, until reset.
- R8: With `remote` low, failed handshakes never clear `ser_en`, and each one sends a long pattern.
- R9: A received lock frame resets the consecutive-failure count to zero.
- R10: `cc_end` has no effect while a pattern is active or `video_start` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cc_end | input | 1 | Control-channel phase has ended (single-cycle pulse) |
| lock_frame | input | 1 | Lock frame received from the receiver; sampled with `cc_end` |
| rate | input | 2 | Pixel rate code; bit 1 selects the longer short pattern |
| remote | input | 1 | Remote mode: enables the retry limit |
| pat_active | output | 1 | A synchronization pattern word is being sent this cycle |
| video_start | output | 1 | One-cycle pulse: the video phase may begin |
| ser_en | output | 1 | Serializer enable; cleared when the retry limit is hit |

## Verification
The assertions check the following on every cycle:
- `video_start` is a lone pulse that directly follows pattern words.
- Every pattern begins in the cycle after an accepted `cc_end`.
- Every finished pattern has one of the three legal lengths.
- Once cleared, `ser_en` stays cleared and the outputs stay quiet.
- `ser_en` only falls while remote mode is set.

Some behaviour needs the bench's scenarios, because it depends on the history of handshakes:
- which of the three lengths a particular handshake and rate code select;
- that a rate change in mid-pattern is ignored;
- that the halt comes on exactly the limit-th consecutive failure and not before;
- that a lock frame restarts the failure count.

// File: rtl/resync_pkg.sv
package resync_pkg;

    typedef enum logic [2:0] {
        ST_LONG   = 3'd0,
        ST_SHORT  = 3'd1,
        ST_VSTART = 3'd2,
        ST_VIDEO  = 3'd3,
        ST_HALT   = 3'd4
    } rs_state_t;

    // Rate codes with bit 1 set use the longer short pattern.
    function automatic logic rate_is_fast(input logic [1:0] code);
        return code[1];
    endfunction

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/rs_len_sel.sv
module rs_len_sel #(
    parameter int unsigned SHORT_LO = 546,
    parameter int unsigned SHORT_HI = 1090,
    parameter int unsigned LONG_LEN = 17410,
    parameter int unsigned CW       = 15
) (
    input  logic          lock_ok,
    input  logic [1:0]    rate,
    output logic [CW-1:0] len_m1
);
    import resync_pkg::*;

    localparam logic [CW-1:0] LO_M1   = CW'(SHORT_LO - 1);
    localparam logic [CW-1:0] HI_M1   = CW'(SHORT_HI - 1);
    localparam logic [CW-1:0] LONG_M1 = CW'(LONG_LEN - 1);

    always_comb begin
        if (!lock_ok)
            len_m1 = LONG_M1;
        else if (rate_is_fast(rate))
            len_m1 = HI_M1;
        else
            len_m1 = LO_M1;
    end
endmodule

// File: rtl/rs_word_ctr.sv
module rs_word_ctr #(
    parameter int unsigned CW      = 15,
    parameter int unsigned RST_VAL = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          last
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= CW'(RST_VAL);
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == '0);
endmodule

// File: rtl/rs_fail_trk.sv
module rs_fail_trk #(
    parameter int unsigned LIMIT = 62
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last_try
);
    generate
        if (LIMIT <= 1) begin : g_single
            assign last_try = 1'b1;
        end else begin : g_count
            localparam int unsigned FW = $clog2(LIMIT);
            localparam logic [FW-1:0] SAT = FW'(LIMIT - 1);
            logic [FW-1:0] fails_q;

            always_ff @(posedge clk) begin
                if (!rst_n)
                    fails_q <= '0;
                else if (clr)
                    fails_q <= '0;
                else if (inc && fails_q != SAT)
                    fails_q <= fails_q + 1'b1;
            end

            assign last_try = (fails_q == SAT);
        end
    endgenerate
endmodule

// File: rtl/resync_seq.sv
module resync_seq #(
    parameter int unsigned SHORT_LO    = 546,
    parameter int unsigned SHORT_HI    = 1090,
    parameter int unsigned LONG_LEN    = 17410,
    parameter int unsigned RETRY_LIMIT = 62
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cc_end,
    input  logic       lock_frame,
    input  logic [1:0] rate,
    input  logic       remote,
    output logic       pat_active,
    output logic       video_start,
    output logic       ser_en
);
    import resync_pkg::*;

    localparam int unsigned MAXL = max3(SHORT_LO, SHORT_HI, LONG_LEN);
    localparam int unsigned CW   = (MAXL < 2) ? 1 : $clog2(MAXL);

    rs_state_t     state_q, state_d;
    logic          decide, halt_now, word_last, last_try;
    logic [CW-1:0] len_m1;

    // Handshake decision is taken only while waiting in the video state.
    assign decide   = (state_q == ST_VIDEO) && cc_end;
    assign halt_now = decide && !lock_frame && remote && last_try;

    rs_len_sel #(
        .SHORT_LO (SHORT_LO),
        .SHORT_HI (SHORT_HI),
        .LONG_LEN (LONG_LEN),
        .CW       (CW)
    ) u_len (
        .lock_ok (lock_frame),
        .rate    (rate),
        .len_m1  (len_m1)
    );

    rs_word_ctr #(
        .CW      (CW),
        .RST_VAL (LONG_LEN - 1)
    ) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (decide && !halt_now),
        .load_val (len_m1),
        .last     (word_last)
    );

    rs_fail_trk #(
        .LIMIT (RETRY_LIMIT)
    ) u_fail (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (decide && lock_frame),
        .inc      (decide && !lock_frame),
        .last_try (last_try)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_LONG;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LONG, ST_SHORT: begin
                if (word_last)
                    state_d = ST_VSTART;
            end
            ST_VSTART: state_d = ST_VIDEO;
            ST_VIDEO: begin
                if (decide) begin
                    if (halt_now)
                        state_d = ST_HALT;
                    else if (lock_frame)
                        state_d = ST_SHORT;
                    else
                        state_d = ST_LONG;
                end
            end
            ST_HALT: state_d = ST_HALT;
            default: state_d = ST_HALT;
        endcase
    end

    always_comb begin
        pat_active  = 1'b0;
        video_start = 1'b0;
        ser_en      = 1'b1;
        unique case (state_q)
            ST_LONG, ST_SHORT: pat_active  = 1'b1;
            ST_VSTART:         video_start = 1'b1;
            ST_VIDEO:          ;
            ST_HALT:           ser_en      = 1'b0;
            default:           ser_en      = 1'b0;
        endcase
    end
endmodule

// File: rtl/resync_seq_chk.sv
module resync_seq_chk #(
    parameter int unsigned SHORT_LO    = 546,
    parameter int unsigned SHORT_HI    = 1090,
    parameter int unsigned LONG_LEN    = 17410,
    parameter int unsigned RETRY_LIMIT = 62
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cc_end,
    input logic       lock_frame,
    input logic [1:0] rate,
    input logic       remote,
    input logic       pat_active,
    input logic       video_start,
    input logic       ser_en
);
    logic [31:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= '0;
        else if (pat_active)
            run_q <= run_q + 1;
        else
            run_q <= '0;
    end

    // R5: the pulse follows pattern words directly and is not overlapped by them
    p_vstart_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        video_start |-> (!pat_active && $past(pat_active)));

    // R5: single-cycle pulse
    p_vstart_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        video_start |=> !video_start);

    // R10: a pattern only begins after an accepted control-channel end
    p_start_on_ccend_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pat_active) |-> $past(cc_end));

    // R2 R3 R4: every finished pattern has a legal length
    p_legal_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pat_active) |-> (run_q == SHORT_LO || run_q == SHORT_HI || run_q == LONG_LEN));

    // R7: disable is sticky
    p_halt_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_en |=> !ser_en);

    // R7: nothing is sent while halted
    p_halt_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_en |-> (!pat_active && !video_start));

    // R8: only remote mode may clear the enable
    p_fall_needs_remote_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ser_en) |-> $past(remote));

    // checker inputs used only by the bound scope
    logic unused_ok;
    assign unused_ok = ^{lock_frame, rate, RETRY_LIMIT[0]};
endmodule

bind resync_seq resync_seq_chk #(
    .SHORT_LO    (SHORT_LO),
    .SHORT_HI    (SHORT_HI),
    .LONG_LEN    (LONG_LEN),
    .RETRY_LIMIT (RETRY_LIMIT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cc_end      (cc_end),
    .lock_frame  (lock_frame),
    .rate        (rate),
    .remote      (remote),
    .pat_active  (pat_active),
    .video_start (video_start),
    .ser_en      (ser_en)
);

// File: tb/sim_resync_seq.sv
`timescale 1ns/1ps
module sim_resync_seq;
    localparam int LO = 5, HI = 9, LG = 20, LIM = 4;

    logic clk = 1'b0, rst_n = 1'b0, cc_end = 1'b0, lock_frame = 1'b0, remote = 1'b0;
    logic [1:0] rate = 2'd0;
    logic pat_active, video_start, ser_en;

    int n_chk = 0, n_bad = 0, fails = 0, cyc = 0;
    bit done = 0;

    always #10 clk = ~clk;

    resync_seq #(.SHORT_LO(LO), .SHORT_HI(HI), .LONG_LEN(LG), .RETRY_LIMIT(LIM)) u0 (
        .clk(clk), .rst_n(rst_n), .cc_end(cc_end), .lock_frame(lock_frame),
        .rate(rate), .remote(remote), .pat_active(pat_active),
        .video_start(video_start), .ser_en(ser_en));

    function automatic int exp_len(input bit lk, input logic [1:0] r);
        if (!lk) return LG;
        return r[1] ? HI : LO;
    endfunction

    function automatic bit exp_halt(input bit lk, input bit rm, input int f);
        return !lk && rm && (f >= LIM - 1);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // Counts active words from the current negedge, then checks the pulse.
    task automatic measure(input int exp, input string tag);
        int n = 0;
        while (pat_active && n < 100000) begin
            n++;
            @(negedge clk);
        end
        chk(n == exp, tag, n, exp);
        chk(video_start == 1'b1, "R5 pulse after last word", int'(video_start), 1);
        @(negedge clk);
        chk(video_start == 1'b0 && !pat_active, "R5 pulse one cycle", int'(video_start), 0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cc_end = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        fails = 0;
        chk(pat_active && ser_en && !video_start, "R1 reset state",
            {pat_active, ser_en, video_start}, 3'b110);
        measure(LG, "R1 power-up long length");
    endtask

    // Drive one handshake in the video state and check the outcome.
    task automatic handshake(input bit lk, input logic [1:0] r, input bit rm,
                             input bit flip_rate, input bit poke, input string tag);
        bit h;
        int e;
        h = exp_halt(lk, rm, fails);
        e = exp_len(lk, r);
        lock_frame = lk;
        rate = r;
        remote = rm;
        cc_end = 1'b1;
        @(negedge clk);
        cc_end = 1'b0;
        if (lk) fails = 0;
        else if (fails < LIM - 1) fails++;
        if (h) begin
            chk(!ser_en && !pat_active && !video_start, "R7 halt on limit",
                {ser_en, pat_active, video_start}, 0);
            cc_end = 1'b1;
            lock_frame = 1'b1;
            repeat (3) @(negedge clk);
            cc_end = 1'b0;
            chk(!ser_en && !pat_active && !video_start, "R7 halt holds under cc_end",
                {ser_en, pat_active, video_start}, 0);
            do_reset();
        end else begin
            chk(ser_en == 1'b1, "R8 enable kept", int'(ser_en), 1);
            if (flip_rate) rate = ~r;
            if (poke) begin
                @(negedge clk);
                cc_end = 1'b1;
                lock_frame = ~lk;
                @(negedge clk);
                cc_end = 1'b0;
                measure(e - 2, tag);
            end else begin
                measure(e, tag);
            end
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                chk(0, "watchdog", cyc, 150000);
                finish_run();
            end
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        // directed corners
        handshake(1, 2'd0, 0, 0, 0, "R2 short rate0");
        handshake(1, 2'd1, 0, 0, 0, "R2 short rate1");
        handshake(1, 2'd2, 0, 0, 0, "R3 short rate2");
        handshake(1, 2'd3, 0, 0, 0, "R3 short rate3");
        handshake(0, 2'd3, 0, 0, 0, "R4 long no lock");
        handshake(1, 2'd0, 0, 1, 0, "R6 rate change mid pattern lo");
        handshake(1, 2'd3, 0, 1, 0, "R6 rate change mid pattern hi");
        handshake(1, 2'd2, 0, 0, 1, "R10 cc_end during pattern");
        for (int i = 0; i < 8; i++) handshake(0, 2'd1, 0, 0, 0, "R8 unlimited retries");
        handshake(1, 2'd0, 1, 0, 0, "R9 lock clears count");
        for (int i = 0; i < LIM - 1; i++) handshake(0, 2'd0, 1, 0, 0, "R9 retry before limit");
        handshake(1, 2'd1, 1, 0, 0, "R9 lock before limit");
        for (int i = 0; i < LIM - 1; i++) handshake(0, 2'd2, 1, 0, 0, "R9 count restarted");
        handshake(0, 2'd2, 1, 0, 0, "R7 final failure");
        // random mix
        for (int i = 0; i < 80; i++) begin
            bit lk, rm;
            logic [1:0] r;
            int gap;
            lk = ($urandom % 3) != 0;
            rm = ($urandom % 2) != 0;
            r = 2'($urandom % 4);
            gap = $urandom % 4;
            repeat (gap) @(negedge clk);
            handshake(lk, r, rm, bit'($urandom % 2), 0, lk ? "R2 R3 random short" : "R4 random long");
        end
        finish_run();
    end
endmodule